// File: doc/BRIEF.md
# Activity-Triggered Auto Powerdown Controller

This block decides when the storage array behind a memory interface needs to be powered. It watches select, write-strobe, the address bus and the data bus, and raises a power-up enable for a fixed number of clock cycles after each qualifying event. When the interval ends with no further events, the enable falls and the array returns to low power. This holds even if select stays asserted, so power follows the rate of cycles and not the length of select.

There are four sources of events. Select falling wakes the block. A write-strobe falling edge wakes it only while select is active. An address transition wakes it only while select is active. A data transition wakes it only while both select and write-strobe are active. An event that arrives during the interval restarts the interval from its full length; the remaining time is never added on. A separate active-low clear input forces the enable high at once, with no clock in the path. Bus transitions are found by comparing each bus with a registered copy, so an event reaches the counter at the clock edge where the new value is first sampled.

Top module: `apd_ctrl`

## Requirements
- R1: After system reset is released, with clear inactive and no event yet, pwr_on is 0 and standby is 1.
- R2: A cycle where ce_n is sampled 0 and was sampled 1 at the previous edge is an event.
- R3: A cycle where we_n is sampled 0 after being sampled 1, with ce_n sampled 0, is an event. While ce_n is 1, a we_n falling edge does not raise pwr_on.
- R4: A change in any addr bit between two consecutive edges, with ce_n sampled 0, is an event.
- R5: A change in any data bit between two consecutive edges, with both ce_n and we_n sampled 0, is an event. A data change while we_n is 1 leaves pwr_on low.
- R6: After the edge that takes the last event, pwr_on stays 1 for exactly HOLD_CYC clock periods. It then stays 0 while ce_n stays 0 and no event occurs.
- R7: An event during the powered interval restarts it at the full HOLD_CYC; intervals never add together.
- R8: At the first edge that samples ce_n as 1 with clr_n high, the block powers down (pwr_on 0). Address and write-strobe activity while ce_n is 1 leaves it down.
- R9: clr_n low drives pwr_on to 1 combinationally. Each edge that samples clr_n low reloads the full interval, so after release with ce_n low and no events, pwr_on stays 1 for HOLD_CYC periods counted from the last such edge.
- R10: standby is always the complement of pwr_on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Active-low array clear; forces power-up |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Address bus |
| data | input | DATA_W | Data bus |
| pwr_on | output | 1 | Array power-up enable |
| standby | output | 1 | High when the array is powered down |

## Verification
The hardest case to reach is a second event that lands partway through a running interval. The bench must see the interval restart at its full length, not extend by the time left, and observing that means counting high cycles after a staggered address change. The data trigger is also narrow, because it needs select and write-strobe both held low while data moves. So the stimulus holds write-strobe low across a data change, then repeats the change with write-strobe high to show it is ignored. A pseudo-random phase then mixes every input, including short clear pulses. A behavioural model checks pwr_on and standby on every clock.

// File: rtl/apd_pkg.sv
package apd_pkg;

   typedef struct packed {
      logic sel_fall;
      logic wr_fall;
      logic adr_move;
      logic dat_move;
   } apd_evt_t;

   function automatic logic apd_any(input apd_evt_t e);
      return e.sel_fall | e.wr_fall | e.adr_move | e.dat_move;
   endfunction

endpackage

// File: rtl/apd_bus_watch.sv
module apd_bus_watch #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic [W-1:0] bus,
   output logic         moved
);

   generate
      if (W < 1) begin : g_bad_width
         $error("apd_bus_watch: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] bus_q;
   logic [W-1:0] bit_diff;

   // Previous sample; follows the bus even during reset so no false edge follows release.
   always_ff @(posedge clk) begin
      bus_q <= bus;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign bit_diff[i] = bus[i] ^ bus_q[i];
      end
   endgenerate

   assign moved = |bit_diff;

endmodule

// File: rtl/apd_evt_gen.sv
module apd_evt_gen
   import apd_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output apd_evt_t          evt
);

   logic ce_q;
   logic we_q;
   logic adr_moved;
   logic dat_moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q <= 1'b1;
         we_q <= 1'b1;
      end else begin
         ce_q <= ce_n;
         we_q <= we_n;
      end
   end

   apd_bus_watch #(.W(ADDR_W)) u_adr_watch (
      .clk   (clk),
      .bus   (addr),
      .moved (adr_moved)
   );

   apd_bus_watch #(.W(DATA_W)) u_dat_watch (
      .clk   (clk),
      .bus   (data),
      .moved (dat_moved)
   );

   always_comb begin
      evt.sel_fall = ce_q & ~ce_n;
      evt.wr_fall  = ~ce_n & we_q & ~we_n;
      evt.adr_move = ~ce_n & adr_moved;
      evt.dat_move = ~ce_n & ~we_n & dat_moved;
   end

endmodule

// File: rtl/apd_timer.sv
module apd_timer #(
   parameter int unsigned HOLD_CYC = 16,
   localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   input  logic ce_n,
   input  logic fire,
   output logic busy
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_CYC);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("apd_timer: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!clr_n) begin
         cnt <= FULL;
      end else if (ce_n) begin
         cnt <= '0;
      end else if (fire) begin
         cnt <= FULL;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

   // R6: idle selected cycles count the interval down one step per clock
   a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !ce_n && !fire && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R7: every event restarts at the full interval, never beyond it
   a_r7_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !ce_n && fire) |=> (cnt == FULL));

   a_r7_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);

endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
   import apd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              pwr_on,
   output logic              standby
);

   apd_evt_t evt;
   logic     tmr_busy;

   apd_evt_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .we_n  (we_n),
      .addr  (addr),
      .data  (data),
      .evt   (evt)
   );

   apd_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_n (clr_n),
      .ce_n  (ce_n),
      .fire  (apd_any(evt)),
      .busy  (tmr_busy)
   );

   // Clear bypasses the counter so power-up needs no clock edge.
   assign pwr_on  = ~clr_n | tmr_busy;
   assign standby = ~pwr_on;

   a_r2_select_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n) |=> pwr_on);

   a_r3_write_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(we_n) && !ce_n) |=> pwr_on);

   a_r4_addr_move: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !$stable(addr)) |=> pwr_on);

   a_r5_data_move: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !we_n && !$stable(data)) |=> pwr_on);

   a_r8_deselect_down: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && $past(ce_n) && clr_n && $past(clr_n)) |-> !pwr_on);

   a_r9_clear_up: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> pwr_on);

   a_r9_release_held: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clr_n) && !ce_n) |-> pwr_on);

   a_r10_standby_inv: assert property (@(posedge clk) disable iff (!rst_n)
      standby != pwr_on);

endmodule

// File: tb/apd_ctrl_bench.sv
module apd_ctrl_bench;

   localparam int AW   = 13;
   localparam int DW   = 8;
   localparam int HOLD = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_n = 1'b1;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          pwr_on;
   logic          standby;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;

   apd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .HOLD_CYC(HOLD)) u_apd_ctrl (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ce_n(ce_n), .we_n(we_n),
      .addr(addr), .data(data), .pwr_on(pwr_on), .standby(standby)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: remaining powered cycles and previous samples
   int            m_left = 0;
   bit            m_pce = 1;
   bit            m_pwe = 1;
   logic [AW-1:0] m_padr = '0;
   logic [DW-1:0] m_pdat = '0;

   always @(posedge clk) begin
      bit hit;
      if (!rst_n) begin
         m_left = 0;
         m_pce  = 1;
         m_pwe  = 1;
      end else begin
         hit = 0;
         if (!ce_n) begin
            if (m_pce) hit = 1;
            if (m_pwe && !we_n) hit = 1;
            if (addr != m_padr) hit = 1;
            if (!we_n && data != m_pdat) hit = 1;
         end
         if (!clr_n)      m_left = HOLD;
         else if (ce_n)   m_left = 0;
         else if (hit)    m_left = HOLD;
         else if (m_left > 0) m_left = m_left - 1;
         m_pce = ce_n;
         m_pwe = we_n;
      end
      m_padr = addr;
      m_pdat = data;
   end

   always @(posedge clk) begin
      bit exp_on;
      #2;
      if (rst_n && !done) begin
         exp_on = (m_left > 0) || !clr_n;
         check(pwr_on === exp_on, "R6 model pwr_on", int'(pwr_on), int'(exp_on));
         check(standby === !exp_on, "R10 model standby", int'(standby), int'(!exp_on));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000 && !done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=0", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic count_high(output int n);
      n = 0;
      for (int k = 0; k < 60; k++) begin
         @(posedge clk);
         #2;
         if (pwr_on) n++;
         else break;
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   initial begin
      int n;
      logic [15:0] lf;
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R1 reset pwr_on", int'(pwr_on), 0);
      check(standby == 1'b1, "R1 reset standby", int'(standby), 1);

      @(negedge clk) ce_n = 1'b0;
      count_high(n);
      check(n == HOLD, "R2 select fall interval", n, HOLD);
      check(n == HOLD, "R6 interval length", n, HOLD);
      idle(2); #2;
      check(pwr_on == 1'b0, "R6 stays down while idle", int'(pwr_on), 0);

      @(negedge clk) addr = 13'h0005;
      count_high(n);
      check(n == HOLD, "R4 address move", n, HOLD);

      @(negedge clk) we_n = 1'b0;
      count_high(n);
      check(n == HOLD, "R3 write fall", n, HOLD);

      @(negedge clk) data = 8'h3c;
      count_high(n);
      check(n == HOLD, "R5 data move with write", n, HOLD);

      @(negedge clk) we_n = 1'b1;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R3 write rise ignored", int'(pwr_on), 0);
      @(negedge clk) data = 8'hc3;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R5 data move without write", int'(pwr_on), 0);
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R5 still down", int'(pwr_on), 0);

      @(negedge clk) addr = 13'h0006;
      idle(3);
      @(negedge clk) addr = 13'h0007;
      count_high(n);
      check(n == HOLD, "R7 restart not stacked", n, HOLD);

      @(negedge clk) addr = 13'h0008;
      idle(2);
      @(negedge clk) ce_n = 1'b1;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R8 deselect powers down", int'(pwr_on), 0);
      check(standby == 1'b1, "R10 standby on deselect", int'(standby), 1);
      @(negedge clk) addr = 13'h0009;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R8 address ignored when deselected", int'(pwr_on), 0);
      @(negedge clk) we_n = 1'b0;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R3 write fall ignored when deselected", int'(pwr_on), 0);
      @(negedge clk) we_n = 1'b1;

      @(negedge clk) clr_n = 1'b0;
      #1;
      check(pwr_on == 1'b1, "R9 clear immediate", int'(pwr_on), 1);
      idle(2);
      @(negedge clk) clr_n = 1'b1;
      @(posedge clk); #2;
      check(pwr_on == 1'b0, "R9 release deselected", int'(pwr_on), 0);

      @(negedge clk) ce_n = 1'b0;
      idle(HOLD + 2);
      @(negedge clk) clr_n = 1'b0;
      #1;
      check(pwr_on == 1'b1, "R9 clear while selected", int'(pwr_on), 1);
      idle(2);
      @(negedge clk) clr_n = 1'b1;
      count_high(n);
      check(n == HOLD - 1, "R9 interval after release", n, HOLD - 1);

      lf = 16'hace1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         ce_n  = (lf[3:0] == 4'h0);
         we_n  = lf[5];
         if (lf[7:6] == 2'b00) addr = lf[15:3];
         if (lf[9:8] == 2'b00) data = lf[15:8];
         clr_n = !(lf[13:10] == 4'h0);
         if (lf[12:9] == 4'h5) begin
            ce_n = 1'b0;
            idle(HOLD + 1);
         end
      end
      @(negedge clk) clr_n = 1'b1;
      idle(2);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule